// File: doc/BRIEF.md
# Scoreboard-checked dispatch-bound reservation station

This block shelves decoded instructions in front of a single execution unit. Each held entry carries only an opcode, two source register numbers and a destination register number. No operand values are stored. Readiness is not kept in the entries. Every cycle, each entry's source numbers index a per-register scoreboard of valid bits that sits beside the register file.

An entry may leave once both of its sources show valid. At most one entry leaves per cycle, and the oldest ready entry wins. The operand values are then read from the register file and registered onto the dispatch outputs, together with the opcode and the destination number.

Issuing an instruction marks its destination register as pending. A result written back through the write-back port stores the value and marks the register valid again. A write-back in the same cycle is visible both to the ready check and to the operand read. Register 0 is hardwired: it always reads zero and is always valid.

Top module: `sbrs_station`

## Requirements
- R1: After reset the station is empty, `iss_full` and `disp_valid` are low, every register is valid, and every register holds zero.
- R2: An issue is accepted when `iss_valid` is high and `iss_full` is low. It stores op, rs1, rs2 and rd. At the next clock edge it clears the valid bit of rd, so an entry reading that register waits.
- R3: A write-back with `wb_valid` high stores `wb_data` into register `wb_rd` and sets its valid bit. If an accepted issue names the same register as its destination in that same cycle, the bit ends cleared.
- R4: An entry is ready only when the valid bits of both rs1 and rs2 are set. An entry with only one source valid stays held.
- R5: At most one entry is dispatched per cycle. Among the ready entries, the one issued earliest is chosen.
- R6: An entry chosen in cycle t appears on the dispatch outputs after the clock edge that ends cycle t. Those outputs are `disp_valid` high with its op and rd, and with `disp_opa` and `disp_opb` equal to the values of rs1 and rs2 as read in cycle t.
- R7: A write-back in cycle t counts as valid for the ready check in cycle t. Its data is also used as the operand value in that cycle.
- R8: `iss_full` is high exactly when all DEPTH entries are occupied. While it is high, an issue is ignored, even in a cycle where a dispatch frees an entry.
- R9: Register 0 always counts as valid and reads as zero. A write-back to it is ignored, and an issue naming it as destination does not make it pending.
- R10: An entry issued in cycle t is first checked for readiness in cycle t+1. It therefore appears on the dispatch outputs no earlier than after the edge that ends cycle t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OPW | Opcode of the issued instruction |
| iss_rs1 | input | REGW | First source register number |
| iss_rs2 | input | REGW | Second source register number |
| iss_rd | input | REGW | Destination register number |
| iss_full | output | 1 | All entries occupied; issue is ignored |
| wb_valid | input | 1 | Result write-back strobe |
| wb_rd | input | REGW | Register being written back |
| wb_data | input | DW | Result value |
| disp_valid | output | 1 | Dispatch output holds an instruction this cycle |
| disp_op | output | OPW | Opcode of the dispatched instruction |
| disp_rd | output | REGW | Destination of the dispatched instruction |
| disp_opa | output | DW | Value of the first source |
| disp_opb | output | DW | Value of the second source |

## Verification
The bench aims at the cases where the scoreboard and the queue interact at the same edge.

- **Same-cycle write-back.** A design without write-first bypassing would hold the entry one extra cycle, or would dispatch the stale register value.
- **Issue and write-back to one register.** A design that let the write-back win would release a consumer before its real producer had finished.
- **Several entries released at once.** A picker scanning in the wrong direction would dispatch the younger entry first.
- **Full station that also dispatches.** Accepting an issue in that cycle would break the rule that fullness alone gates issue.
- **Register 0.** A write-back to register 0 must be ignored, and a destination of 0 must not leave entries waiting forever.

// File: rtl/sbrs_pkg.sv
package sbrs_pkg;
  parameter int OPW  = 4;
  parameter int NREG = 16;
  parameter int DW   = 16;
  localparam int REGW = $clog2(NREG);

  typedef struct packed {
    logic [OPW-1:0]  op;
    logic [REGW-1:0] rs1;
    logic [REGW-1:0] rs2;
    logic [REGW-1:0] rd;
  } slot_t;
endpackage

// File: rtl/sbrs_regstate.sv
module sbrs_regstate
  import sbrs_pkg::*;
#(
  parameter bit HARD_ZERO = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wb_valid,
  input  logic [REGW-1:0] wb_rd,
  input  logic [DW-1:0]   wb_data,
  input  logic            clr_valid,
  input  logic [REGW-1:0] clr_rd,
  input  logic [REGW-1:0] rda_idx,
  input  logic [REGW-1:0] rdb_idx,
  output logic [NREG-1:0] sb_bits,
  output logic [NREG-1:0] sb_eff,
  output logic [DW-1:0]   rda_data,
  output logic [DW-1:0]   rdb_data
);
  logic [DW-1:0] rf_view [NREG];
  logic [NREG-1:0] wb_hit;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    if (HARD_ZERO && r == 0) begin : g_fixed
      assign wb_hit[r]  = 1'b0;
      assign sb_bits[r] = 1'b1;
      assign sb_eff[r]  = 1'b1;
      assign rf_view[r] = '0;
    end else begin : g_live
      logic          v_q, v_d;
      logic [DW-1:0] d_q;
      logic          clr_hit;

      assign wb_hit[r] = wb_valid && (wb_rd == REGW'(r));
      assign clr_hit   = clr_valid && (clr_rd == REGW'(r));

      always_comb begin
        v_d = v_q;
        if (wb_hit[r]) v_d = 1'b1;
        if (clr_hit)   v_d = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= 1'b1;
        else        v_q <= v_d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         d_q <= '0;
        else if (wb_hit[r]) d_q <= wb_data;
      end

      assign sb_bits[r] = v_q;
      assign sb_eff[r]  = v_q | wb_hit[r];
      assign rf_view[r] = d_q;
    end
  end

  assign rda_data = wb_hit[rda_idx] ? wb_data : rf_view[rda_idx];
  assign rdb_data = wb_hit[rdb_idx] ? wb_data : rf_view[rdb_idx];
endmodule

// File: rtl/sbrs_queue.sv
module sbrs_queue
  import sbrs_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  slot_t                   push_ent,
  input  logic                    pop,
  input  logic [IW-1:0]           pop_idx,
  output slot_t [DEPTH-1:0]       ents,
  output logic  [DEPTH-1:0]       occ,
  output logic                    full
);
  typedef slot_t [DEPTH-1:0] bank_t;

  bank_t          ent_q, ent_d, shifted;
  logic [CW-1:0]  cnt_q, cnt_d, tail;

  assign shifted = bank_t'(ent_q >> $bits(slot_t));
  assign tail    = cnt_q - CW'(pop);

  always_comb begin
    ent_d = ent_q;
    if (pop) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (IW'(i) >= pop_idx) ent_d[i] = shifted[i];
      end
    end
    if (push) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (tail == CW'(i)) ent_d[i] = push_ent;
      end
    end
    cnt_d = tail + CW'(push);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (push || pop) ent_q <= ent_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_occ
    assign occ[i] = CW'(i) < cnt_q;
  end

  assign ents = ent_q;
  assign full = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/sbrs_pick.sv
module sbrs_pick #(
  parameter int DEPTH = 4,
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] req,
  output logic             any,
  output logic [IW-1:0]    idx,
  output logic [DEPTH-1:0] gnt
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    gnt = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req[i]) begin
        any    = 1'b1;
        idx    = IW'(i);
        gnt    = '0;
        gnt[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbrs_station.sv
module sbrs_station
  import sbrs_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter bit HARD_ZERO = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_valid,
  input  logic [OPW-1:0]  iss_op,
  input  logic [REGW-1:0] iss_rs1,
  input  logic [REGW-1:0] iss_rs2,
  input  logic [REGW-1:0] iss_rd,
  output logic            iss_full,
  input  logic            wb_valid,
  input  logic [REGW-1:0] wb_rd,
  input  logic [DW-1:0]   wb_data,
  output logic            disp_valid,
  output logic [OPW-1:0]  disp_op,
  output logic [REGW-1:0] disp_rd,
  output logic [DW-1:0]   disp_opa,
  output logic [DW-1:0]   disp_opb
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  slot_t [DEPTH-1:0] ents;
  slot_t             new_ent, sel_ent;
  logic [DEPTH-1:0]  occ, rdy, gnt;
  logic [NREG-1:0]   sb_bits, sb_eff;
  logic [IW-1:0]     pick_idx;
  logic              pick_any, full_w, accept;
  logic [DW-1:0]     opa_w, opb_w;

  assign accept  = iss_valid && !full_w;
  assign new_ent = '{op: iss_op, rs1: iss_rs1, rs2: iss_rs2, rd: iss_rd};

  sbrs_queue #(.DEPTH(DEPTH)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accept),
    .push_ent (new_ent),
    .pop      (pick_any),
    .pop_idx  (pick_idx),
    .ents     (ents),
    .occ      (occ),
    .full     (full_w)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_rdy
    assign rdy[i] = occ[i] && sb_eff[ents[i].rs1] && sb_eff[ents[i].rs2];
  end

  sbrs_pick #(.DEPTH(DEPTH)) u_pick (
    .req (rdy),
    .any (pick_any),
    .idx (pick_idx),
    .gnt (gnt)
  );

  assign sel_ent = ents[pick_idx];

  sbrs_regstate #(.HARD_ZERO(HARD_ZERO)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wb_valid  (wb_valid),
    .wb_rd     (wb_rd),
    .wb_data   (wb_data),
    .clr_valid (accept),
    .clr_rd    (iss_rd),
    .rda_idx   (sel_ent.rs1),
    .rdb_idx   (sel_ent.rs2),
    .sb_bits   (sb_bits),
    .sb_eff    (sb_eff),
    .rda_data  (opa_w),
    .rdb_data  (opb_w)
  );

  logic            dv_q, dv_d;
  logic [OPW-1:0]  op_q;
  logic [REGW-1:0] rd_q;
  logic [DW-1:0]   a_q, b_q;

  assign dv_d = pick_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dv_q <= 1'b0;
    else        dv_q <= dv_d;
  end

  always_ff @(posedge clk) begin
    if (pick_any) begin
      op_q <= sel_ent.op;
      rd_q <= sel_ent.rd;
      a_q  <= opa_w;
      b_q  <= opb_w;
    end
  end

  assign iss_full   = full_w;
  assign disp_valid = dv_q;
  assign disp_op    = op_q;
  assign disp_rd    = rd_q;
  assign disp_opa   = a_q;
  assign disp_opb   = b_q;
endmodule

// File: rtl/sbrs_station_chk.sv
module sbrs_station_chk
  import sbrs_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter bit HARD_ZERO = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iss_valid,
  input logic [REGW-1:0] iss_rd,
  input logic            iss_full,
  input logic            wb_valid,
  input logic [REGW-1:0] wb_rd,
  input logic            disp_valid,
  input logic [DEPTH-1:0] rdy,
  input logic [DEPTH-1:0] gnt,
  input logic            pick_any,
  input logic [NREG-1:0] sb_bits
);
  a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r4_grant_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~rdy) == '0);

  a_r5_oldest_first: assert property (@(posedge clk) disable iff (!rst_n)
    pick_any |-> ((rdy & (gnt - DEPTH'(1))) == '0));

  a_r6_dispatch_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pick_any |=> disp_valid);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_any |=> !disp_valid);

  a_r2_issue_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_full && (iss_rd != '0 || !HARD_ZERO))
      |=> !sb_bits[$past(iss_rd)]);

  a_r3_wb_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !(iss_valid && !iss_full && iss_rd == wb_rd))
      |=> sb_bits[$past(wb_rd)]);

  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_full && !pick_any) |=> iss_full);
endmodule

bind sbrs_station sbrs_station_chk #(.DEPTH(DEPTH), .HARD_ZERO(HARD_ZERO)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_valid  (iss_valid),
  .iss_rd     (iss_rd),
  .iss_full   (iss_full),
  .wb_valid   (wb_valid),
  .wb_rd      (wb_rd),
  .disp_valid (disp_valid),
  .rdy        (rdy),
  .gnt        (gnt),
  .pick_any   (pick_any),
  .sb_bits    (sb_bits)
);

// File: tb/sim_sbrs_station.sv
`timescale 1ns/1ps
module sim_sbrs_station;
  import sbrs_pkg::*;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic iss_valid, wb_valid, iss_full, disp_valid;
  logic [OPW-1:0]  iss_op, disp_op;
  logic [REGW-1:0] iss_rs1, iss_rs2, iss_rd, wb_rd, disp_rd;
  logic [DW-1:0]   wb_data, disp_opa, disp_opb;

  always #2 clk = ~clk;

  sbrs_station #(.DEPTH(DEPTH), .HARD_ZERO(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_rs1(iss_rs1),
    .iss_rs2(iss_rs2), .iss_rd(iss_rd), .iss_full(iss_full),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data),
    .disp_valid(disp_valid), .disp_op(disp_op), .disp_rd(disp_rd),
    .disp_opa(disp_opa), .disp_opb(disp_opb)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  bit              m_sb [NREG];
  logic [DW-1:0]   m_rf [NREG];
  logic [OPW-1:0]  q_op [DEPTH];
  logic [REGW-1:0] q_r1 [DEPTH], q_r2 [DEPTH], q_rd [DEPTH];
  int              q_n;
  bit              e_dv, e_full;
  logic [OPW-1:0]  e_op;
  logic [REGW-1:0] e_rd;
  logic [DW-1:0]   e_a, e_b;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit src_ok(logic [REGW-1:0] r, bit wv, logic [REGW-1:0] wr);
    return (r == 0) || m_sb[r] || (wv && wr == r);
  endfunction

  function automatic logic [DW-1:0] src_val(logic [REGW-1:0] r, bit wv,
                                            logic [REGW-1:0] wr, logic [DW-1:0] wd);
    if (r == 0) return '0;
    if (wv && wr == r) return wd;
    return m_rf[r];
  endfunction

  task automatic model_reset();
    for (int r = 0; r < NREG; r++) begin
      m_sb[r] = 1'b1;
      m_rf[r] = '0;
    end
    q_n = 0;
    e_dv = 0;
    e_full = 0;
  endtask

  task automatic model_step(bit iv, logic [OPW-1:0] op, logic [REGW-1:0] r1,
                            logic [REGW-1:0] r2, logic [REGW-1:0] rd,
                            bit wv, logic [REGW-1:0] wr, logic [DW-1:0] wd);
    bit was_full = (q_n == DEPTH);
    int sel = -1;
    e_dv = 0;
    for (int i = 0; i < q_n; i++) begin
      if (sel < 0 && src_ok(q_r1[i], wv, wr) && src_ok(q_r2[i], wv, wr)) sel = i;
    end
    if (sel >= 0) begin
      e_dv = 1;
      e_op = q_op[sel];
      e_rd = q_rd[sel];
      e_a  = src_val(q_r1[sel], wv, wr, wd);
      e_b  = src_val(q_r2[sel], wv, wr, wd);
      for (int i = sel; i < q_n - 1; i++) begin
        q_op[i] = q_op[i+1]; q_r1[i] = q_r1[i+1];
        q_r2[i] = q_r2[i+1]; q_rd[i] = q_rd[i+1];
      end
      q_n--;
    end
    if (iv && !was_full) begin
      q_op[q_n] = op; q_r1[q_n] = r1; q_r2[q_n] = r2; q_rd[q_n] = rd;
      q_n++;
    end
    if (wv && wr != 0) begin
      m_sb[wr] = 1'b1;
      m_rf[wr] = wd;
    end
    if (iv && !was_full && rd != 0) m_sb[rd] = 1'b0;
    e_full = (q_n == DEPTH);
  endtask

  // drive one cycle at a falling edge, compare at the next falling edge
  task automatic cyc(bit iv, logic [OPW-1:0] op, logic [REGW-1:0] r1,
                     logic [REGW-1:0] r2, logic [REGW-1:0] rd,
                     bit wv, logic [REGW-1:0] wr, logic [DW-1:0] wd, string tag);
    string otag;
    iss_valid = iv; iss_op = op; iss_rs1 = r1; iss_rs2 = r2; iss_rd = rd;
    wb_valid = wv; wb_rd = wr; wb_data = wd;
    model_step(iv, op, r1, r2, rd, wv, wr, wd);
    @(negedge clk);
    otag = (tag == "R5") ? "R6" : tag;
    chk(disp_valid == e_dv, tag, "disp_valid", 32'(disp_valid), 32'(e_dv));
    if (e_dv && disp_valid) begin
      chk(disp_op == e_op, tag, "disp_op", 32'(disp_op), 32'(e_op));
      chk(disp_rd == e_rd, tag, "disp_rd", 32'(disp_rd), 32'(e_rd));
      chk(disp_opa == e_a, otag, "disp_opa", 32'(disp_opa), 32'(e_a));
      chk(disp_opb == e_b, otag, "disp_opb", 32'(disp_opb), 32'(e_b));
    end
    chk(iss_full == e_full, "R8", "iss_full", 32'(iss_full), 32'(e_full));
  endtask

  task automatic idle(string tag);
    cyc(0, '0, '0, '0, '0, 0, '0, '0, tag);
  endtask

  task automatic wb(logic [REGW-1:0] r, logic [DW-1:0] d, string tag);
    cyc(0, '0, '0, '0, '0, 1, r, d, tag);
  endtask

  task automatic iss(logic [OPW-1:0] op, logic [REGW-1:0] r1, logic [REGW-1:0] r2,
                     logic [REGW-1:0] rd, string tag);
    cyc(1, op, r1, r2, rd, 0, '0, '0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    rst_n = 1'b0;
    iss_valid = 0; iss_op = '0; iss_rs1 = '0; iss_rs2 = '0; iss_rd = '0;
    wb_valid = 0; wb_rd = '0; wb_data = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: empty and idle after reset
    chk(disp_valid == 0, "R1", "disp_valid", 32'(disp_valid), 0);
    chk(iss_full == 0, "R1", "iss_full", 32'(iss_full), 0);

    // R1 / R10: zero-valued sources dispatch two cycles after issue
    iss(4'h3, 4'd3, 4'd4, 4'd1, "R10");
    idle("R10");

    // R2: consumer of pending r1 waits
    iss(4'h5, 4'd1, 4'd0, 4'd2, "R2");
    repeat (3) idle("R2");

    // R7: write-back seen in the same cycle, data bypassed
    wb(4'd1, 16'h1234, "R7");
    idle("R7");

    // R3: write-back updates value and bit
    wb(4'd9, 16'hBEEF, "R3");
    iss(4'h6, 4'd9, 4'd9, 4'd10, "R3");
    idle("R3");
    // R3: issue and write-back to r9 together; issue wins
    cyc(1, 4'h7, 4'd0, 4'd0, 4'd9, 1, 4'd9, 16'h0001, "R3");
    iss(4'h8, 4'd9, 4'd0, 4'd11, "R3");
    repeat (2) idle("R3");
    wb(4'd9, 16'h0055, "R3");
    idle("R3");

    // R4: one source valid, the other pending
    iss(4'h9, 4'd11, 4'd0, 4'd12, "R4");
    repeat (2) idle("R4");
    wb(4'd11, 16'h0A0A, "R4");
    idle("R4");

    // R9: register 0 ignores writes and never becomes pending
    wb(4'd0, 16'hFFFF, "R9");
    iss(4'hA, 4'd0, 4'd0, 4'd0, "R9");
    iss(4'hB, 4'd0, 4'd0, 4'd3, "R9");
    repeat (2) idle("R9");

    // R5: younger released first, then two released at once
    iss(4'h1, 4'd0, 4'd0, 4'd4, "R5");
    iss(4'h1, 4'd0, 4'd0, 4'd6, "R5");
    iss(4'h1, 4'd0, 4'd0, 4'd7, "R5");
    iss(4'hC, 4'd4, 4'd0, 4'd8, "R5");
    iss(4'hD, 4'd6, 4'd0, 4'd8, "R5");
    iss(4'hE, 4'd7, 4'd7, 4'd8, "R5");
    wb(4'd6, 16'h0606, "R5");
    iss(4'hF, 4'd7, 4'd0, 4'd5, "R5");
    wb(4'd7, 16'h0707, "R5");
    repeat (2) idle("R5");
    wb(4'd4, 16'h0404, "R5");
    idle("R5");

    // R8: fill, reject, and reject even when dispatching
    iss(4'h2, 4'd0, 4'd0, 4'd13, "R8");
    idle("R8");
    for (int k = 0; k < DEPTH + 1; k++) iss(4'(k), 4'd13, 4'd0, 4'd14, "R8");
    idle("R8");
    cyc(1, 4'h9, 4'd0, 4'd0, 4'd15, 1, 4'd13, 16'h1313, "R8");
    repeat (DEPTH + 2) idle("R8");

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      bit iv = ($urandom_range(0, 1) == 1);
      bit wv = ($urandom_range(0, 2) != 0);
      cyc(iv, 4'($urandom_range(0, 15)), 4'($urandom_range(0, 7)),
          4'($urandom_range(0, 7)), 4'($urandom_range(0, 7)),
          wv, 4'($urandom_range(0, 7)), 16'($urandom), "R5");
    end
    for (int r = 0; r < 8; r++) wb(4'(r), 16'(r * 3), "R5");
    repeat (DEPTH + 2) idle("R5");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule